// File: doc/BRIEF.md
# Serial RAM Block Transfer Sequencer

This block receives a serial write frame aimed at a RAM of 32-bit words and turns it into a series of whole-word writes on a simple synchronous RAM write port. Within a chip-select frame, the first byte is an instruction. When that byte selects the RAM for writing, the block reads a begin address and a final address from one of four segment descriptors, chosen by a 2-bit profile input. The number of words it writes is the inclusive span between those two addresses.

The bit-order mode sets three things at once: the order of bits inside each serial byte, the order of bytes inside each word, and whether the RAM address sweeps down from the final address or up from the begin address. A one-clock done pulse marks the last write. Any bytes that follow it in the same frame are dropped. The segment descriptors and the RAM array itself are supplied from outside.

Top module: `srb_seq_top`

## Requirements
- R1: Serial bits are taken on clocks where `bit_stb` is high while `cs_n` is low. Each group of 8 forms a byte. With `lsb_first`=0 the first bit is byte bit 7. With `lsb_first`=1 the first bit is byte bit 0.
- R2: The first byte of a frame is the instruction. Only a byte with bit 7 = 0 (write) and bits 4:0 = 01011b (value 0Bh) starts a RAM transfer. Any other first byte causes no RAM write and no done pulse for the rest of the frame.
- R3: With `lsb_first`=0, the first word is written to the final address, and its first byte lands in bits 31:24. Each later word goes to the next lower address, down to and including the begin address.
- R4: With `lsb_first`=1, the first word is written to the begin address, and its first byte lands in bits 7:0. Each later word goes to the next higher address, up to and including the final address.
- R5: A transfer with final ≥ begin writes exactly final − begin + 1 words.
- R6: When final < begin, a single word is written at the begin address.
- R7: Each word is written with a single one-cycle `ram_we` pulse, only after all four of its bytes have arrived. The written address always lies within the sampled segment.
- R8: A word that is still incomplete when `cs_n` rises is discarded and never written. The next frame starts with an empty word.
- R9: `done` is high for exactly one clock: the clock right after the `ram_we` pulse of the last word.
- R10: Bytes that follow the last word in the same frame cause no write and no further `done`.
- R11: The profile selection and both segment addresses are sampled when the instruction byte completes. Changing them later in the frame has no effect on that transfer.
- R12: After reset, `ram_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select, active low; high ends the frame |
| bit_stb | input | 1 | Qualifies `bit_dat` for one clock |
| bit_dat | input | 1 | Serial data bit |
| lsb_first | input | 1 | Bit-order mode: 1 = least significant first; hold stable during a frame |
| prof_sel | input | 2 | Selects one of four segment descriptors |
| seg_beg | input | 40 | Four packed 10-bit begin addresses; profile p occupies bits p*10 +: 10 |
| seg_fin | input | 40 | Four packed 10-bit final addresses, same packing as `seg_beg` |
| ram_we | output | 1 | RAM write enable, one cycle per word |
| ram_addr | output | 10 | RAM word address, valid while `ram_we` is high |
| ram_wdata | output | 32 | RAM write data, valid while `ram_we` is high |
| done | output | 1 | One-clock pulse after the last word of a transfer is written |

## Verification
The embedded assertions check, on every clock, that each byte and word strobe lasts one cycle and that `done` follows a write. They also check that no write follows `done`, that every write address stays inside the sampled segment, and that the address moves by exactly one word in the direction set by the mode. The following can only be shown by the bench scenarios, which compare the logged writes against values built from the requirements:
- exact byte packing and bit order;
- the total word count;
- the reversed-segment fallback;
- rejection of foreign instructions;
- discarding of partial words;
- insensitivity to profile changes after the instruction.

// File: rtl/srb_pkg.sv
// Package: shared types and constants for the serial RAM block transfer sequencer.
// Assumes: one instruction byte per frame, 32-bit RAM words built from 8-bit bytes.
package srb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // waiting for the instruction byte
        SQ_MOVE = 2'd1,   // transferring words
        SQ_HALT = 2'd2    // frame finished or rejected; bytes ignored
    } sq_state_t;
endpackage

// File: rtl/srb_byte_rx.sv
// Module: srb_byte_rx
// Collects qualified serial bits into bytes while the frame is active.
// Assumes: lsb_first is stable during a frame. A high cs_n clears any partial byte.
module srb_byte_rx
    import srb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              bit_stb,
    input  logic              bit_dat,
    input  logic              lsb_first,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    // Shift in one bit per strobe and flag a byte after the eighth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (bit_stb) begin
                if (lsb_first) begin
                    shreg <= {bit_dat, shreg[BYTE_W-1:1]};
                end else begin
                    shreg <= {shreg[BYTE_W-2:0], bit_dat};
                end
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_vld <= 1'b1;
                end
            end
        end
    end

    assign byte_q = shreg;

    // R1
    byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/srb_word_pack.sv
// Module: srb_word_pack
// Packs accepted bytes into a RAM word and pulses word_vld once the word is full.
// Assumes: lsb_mode is held for the whole transfer. A high cs_n drops a partial word.
module srb_word_pack
    import srb_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_q,
    input  logic              accept,
    input  logic              lsb_mode,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_q
);
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int BC_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [BC_W-1:0] byte_cnt;
    logic            take;

    assign take = byte_vld && accept && !cs_n;

    // Place each byte at the end chosen by the mode and release the full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (cs_n) begin
                byte_cnt <= '0;
            end else if (take) begin
                if (lsb_mode) begin
                    word_q <= {byte_q, word_q[WORD_W-1:BYTE_W]};
                end else begin
                    word_q <= {word_q[WORD_W-BYTE_W-1:0], byte_q};
                end
                if (byte_cnt == BC_W'(NBYTES - 1)) begin
                    byte_cnt <= '0;
                    word_vld <= 1'b1;
                end else begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

    // R7
    word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    // R7
    word_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(byte_vld));
endmodule

// File: rtl/srb_seq_ctl.sv
// Module: srb_seq_ctl
// Decodes the instruction byte, samples the selected segment and steps the word address.
// Assumes: the segment descriptors are packed ADDR_W fields, with profile p at p*ADDR_W.
module srb_seq_ctl
    import srb_pkg::*;
#(
    parameter int          ADDR_W  = 10,
    parameter int          PROF_W  = 2,
    parameter logic [4:0]  RAM_SEL = 5'b01011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          byte_vld,
    input  logic [BYTE_W-1:0]             byte_q,
    input  logic [PROF_W-1:0]             prof_sel,
    input  logic [(ADDR_W<<PROF_W)-1:0]   seg_beg,
    input  logic [(ADDR_W<<PROF_W)-1:0]   seg_fin,
    input  logic                          lsb_first,
    input  logic                          word_vld,
    output logic                          xfer_en,
    output logic                          lsb_lat,
    output logic [ADDR_W-1:0]             cur_addr,
    output logic                          done
);
    localparam int NSEG = 1 << PROF_W;

    sq_state_t         state;
    logic [ADDR_W-1:0] stop_addr;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic [ADDR_W-1:0] pick_beg;
    logic [ADDR_W-1:0] pick_fin;
    logic [ADDR_W-1:0] pick_start;
    logic [ADDR_W-1:0] pick_stop;
    logic [ADDR_W-1:0] pick_hi;
    logic              instr_hit;
    logic              last_word;

    // Select the begin and final addresses of the profile currently on the pins.
    always_comb begin
        pick_beg = '0;
        pick_fin = '0;
        for (int p = 0; p < NSEG; p++) begin
            if (prof_sel == PROF_W'(p)) begin
                pick_beg = seg_beg[p*ADDR_W +: ADDR_W];
                pick_fin = seg_fin[p*ADDR_W +: ADDR_W];
            end
        end
    end

    // Work out the start, stop and upper bound of the sweep, folding a reversed segment to one word.
    always_comb begin
        if (pick_fin < pick_beg) begin
            pick_start = pick_beg;
            pick_stop  = pick_beg;
            pick_hi    = pick_beg;
        end else if (lsb_first) begin
            pick_start = pick_beg;
            pick_stop  = pick_fin;
            pick_hi    = pick_fin;
        end else begin
            pick_start = pick_fin;
            pick_stop  = pick_beg;
            pick_hi    = pick_fin;
        end
    end

    assign instr_hit = (byte_q[BYTE_W-1] == 1'b0) && (byte_q[4:0] == RAM_SEL);
    assign last_word = (cur_addr == stop_addr);

    // Frame state machine: wait for the instruction, move words, then ignore the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            cur_addr  <= '0;
            stop_addr <= '0;
            lo_addr   <= '0;
            hi_addr   <= '0;
            lsb_lat   <= 1'b0;
        end else if (cs_n) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (byte_vld) begin
                        if (instr_hit) begin
                            state     <= SQ_MOVE;
                            cur_addr  <= pick_start;
                            stop_addr <= pick_stop;
                            lo_addr   <= pick_beg;
                            hi_addr   <= pick_hi;
                            lsb_lat   <= lsb_first;
                        end else begin
                            state <= SQ_HALT;
                        end
                    end
                end
                SQ_MOVE: begin
                    if (word_vld) begin
                        if (last_word) begin
                            state <= SQ_HALT;
                        end else if (lsb_lat) begin
                            cur_addr <= cur_addr + 1'b1;
                        end else begin
                            cur_addr <= cur_addr - 1'b1;
                        end
                    end
                end
                default: state <= SQ_HALT;
            endcase
        end
    end

    // Raise done for one clock after the last word's write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= word_vld && (state == SQ_MOVE) && last_word;
        end
    end

    assign xfer_en = (state == SQ_MOVE);

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(word_vld));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    addr_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && state == SQ_MOVE) |-> (cur_addr >= lo_addr && cur_addr <= hi_addr));
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_MOVE && word_vld && !last_word && !cs_n) |=>
        (cur_addr == (lsb_lat ? ADDR_W'($past(cur_addr) + 1'b1)
                              : ADDR_W'($past(cur_addr) - 1'b1))));
endmodule

// File: rtl/srb_seq_top.sv
// Module: srb_seq_top
// Top of the serial RAM block transfer sequencer: byte receiver, control and word packer.
// Assumes: lsb_first and the segment inputs are driven from settled configuration state.
module srb_seq_top
    import srb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PROF_W = 2,
    parameter int WORD_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         bit_stb,
    input  logic                         bit_dat,
    input  logic                         lsb_first,
    input  logic [PROF_W-1:0]            prof_sel,
    input  logic [(ADDR_W<<PROF_W)-1:0]  seg_beg,
    input  logic [(ADDR_W<<PROF_W)-1:0]  seg_fin,
    output logic                         ram_we,
    output logic [ADDR_W-1:0]            ram_addr,
    output logic [WORD_W-1:0]            ram_wdata,
    output logic                         done
);
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;
    logic              xfer_en;
    logic              lsb_lat;
    logic              word_vld;
    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] cur_addr;

    srb_byte_rx u_byte_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .bit_stb   (bit_stb),
        .bit_dat   (bit_dat),
        .lsb_first (lsb_first),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q)
    );

    srb_seq_ctl #(
        .ADDR_W (ADDR_W),
        .PROF_W (PROF_W)
    ) u_seq_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q),
        .prof_sel  (prof_sel),
        .seg_beg   (seg_beg),
        .seg_fin   (seg_fin),
        .lsb_first (lsb_first),
        .word_vld  (word_vld),
        .xfer_en   (xfer_en),
        .lsb_lat   (lsb_lat),
        .cur_addr  (cur_addr),
        .done      (done)
    );

    srb_word_pack #(
        .WORD_W (WORD_W)
    ) u_word_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .byte_vld (byte_vld),
        .byte_q   (byte_q),
        .accept   (xfer_en),
        .lsb_mode (lsb_lat),
        .word_vld (word_vld),
        .word_q   (word_q)
    );

    assign ram_we    = word_vld;
    assign ram_addr  = cur_addr;
    assign ram_wdata = word_q;

    // R10
    no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ram_we);
    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ram_we && !done));
endmodule

// File: tb/test_srb_seq_top.sv
`timescale 1ns/1ps
module test_srb_seq_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          bit_stb = 1'b0;
    logic          bit_dat = 1'b0;
    logic          lsb_first = 1'b0;
    logic [1:0]    prof_sel = 2'd0;
    logic [4*AW-1:0] seg_beg = '0;
    logic [4*AW-1:0] seg_fin = '0;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_wdata;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_wr = 0;
    int n_done = 0;
    int done_cyc = 0;
    int last_we_cyc = 0;
    logic [AW-1:0] wa [0:15];
    logic [31:0]   wd [0:15];

    always #2.5 clk = ~clk;

    srb_seq_top i_srb_seq_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .bit_dat(bit_dat),
        .lsb_first(lsb_first), .prof_sel(prof_sel), .seg_beg(seg_beg), .seg_fin(seg_fin),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .done(done)
    );

    // Log writes and done pulses, sampled away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && ram_we) begin
            if (n_wr < 16) begin
                wa[n_wr] <= ram_addr;
                wd[n_wr] <= ram_wdata;
            end
            n_wr <= n_wr + 1;
            last_we_cyc <= cyc;
        end
        if (rst_n && done) begin
            n_done <= n_done + 1;
            done_cyc <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_seg(input int p, input int b, input int f);
        seg_beg[p*AW +: AW] = AW'(b);
        seg_fin[p*AW +: AW] = AW'(f);
    endtask

    task automatic clear_log();
        @(negedge clk);
        n_wr = 0;
        n_done = 0;
    endtask

    task automatic frame_open();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            bit_dat = lsb_first ? b[i] : b[7-i];
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic send_run(input logic [7:0] base, input int cnt);
        for (int k = 0; k < cnt; k++) send_byte(base + 8'(k));
    endtask

    // R12: outputs idle after reset
    task automatic t_reset();
        @(negedge clk);
        chk(ram_we == 1'b0, "R12 ram_we", ram_we, 0);
        chk(done == 1'b0, "R12 done", done, 0);
    endtask

    // R3 R5 R9 R1: MSB-first sweep down from final to begin
    task automatic t_msb_sweep();
        clear_log();
        lsb_first = 1'b0; prof_sel = 2'd1;
        frame_open(); send_byte(8'h0B); send_run(8'h10, 12); frame_close();
        chk(n_wr == 3, "R5 word count", n_wr, 3);
        chk(wa[0] == 6 && wd[0] == 32'h10111213, "R3 first word", {wa[0], wd[0]}, {10'd6, 32'h10111213});
        chk(wa[1] == 5 && wd[1] == 32'h14151617, "R3 second word", {wa[1], wd[1]}, {10'd5, 32'h14151617});
        chk(wa[2] == 4 && wd[2] == 32'h18191A1B, "R1 third word", {wa[2], wd[2]}, {10'd4, 32'h18191A1B});
        chk(n_done == 1, "R9 done count", n_done, 1);
        chk(done_cyc == last_we_cyc + 1, "R9 done timing", done_cyc, last_we_cyc + 1);
    endtask

    // R4 R1: LSB-first sweep up from begin to final, bits sent LSB first
    task automatic t_lsb_sweep();
        clear_log();
        lsb_first = 1'b1; prof_sel = 2'd2;
        frame_open(); send_byte(8'h0B); send_run(8'h21, 12); frame_close();
        chk(n_wr == 3, "R5 word count lsb", n_wr, 3);
        chk(wa[0] == 8 && wd[0] == 32'h24232221, "R4 first word", {wa[0], wd[0]}, {10'd8, 32'h24232221});
        chk(wa[1] == 9 && wd[1] == 32'h28272625, "R1 second word", {wa[1], wd[1]}, {10'd9, 32'h28272625});
        chk(wa[2] == 10 && wd[2] == 32'h2C2B2A29, "R4 third word", {wa[2], wd[2]}, {10'd10, 32'h2C2B2A29});
        chk(n_done == 1, "R9 done lsb", n_done, 1);
        lsb_first = 1'b0;
    endtask

    // R10 R7: single-word segment followed by extra bytes in the frame
    task automatic t_extra_bytes();
        clear_log();
        prof_sel = 2'd0;
        frame_open(); send_byte(8'h0B); send_run(8'h30, 8); frame_close();
        chk(n_wr == 1, "R10 writes", n_wr, 1);
        chk(wa[0] == 3 && wd[0] == 32'h30313233, "R7 single word", {wa[0], wd[0]}, {10'd3, 32'h30313233});
        chk(n_done == 1, "R10 done count", n_done, 1);
    endtask

    // R6: final below begin writes one word at begin
    task automatic t_reversed();
        clear_log();
        prof_sel = 2'd3;
        frame_open(); send_byte(8'h0B); send_run(8'h40, 8); frame_close();
        chk(n_wr == 1, "R6 writes", n_wr, 1);
        chk(wa[0] == 12 && wd[0] == 32'h40414243, "R6 word", {wa[0], wd[0]}, {10'd12, 32'h40414243});
    endtask

    // R2: read instruction and another address are ignored
    task automatic t_bad_instr();
        clear_log();
        prof_sel = 2'd1;
        frame_open(); send_byte(8'h8B); send_run(8'h50, 8); frame_close();
        frame_open(); send_byte(8'h0A); send_run(8'h58, 8); frame_close();
        chk(n_wr == 0, "R2 writes", n_wr, 0);
        chk(n_done == 0, "R2 done", n_done, 0);
    endtask

    // R8: partial word dropped, next frame starts clean
    task automatic t_partial();
        clear_log();
        prof_sel = 2'd0;
        frame_open(); send_byte(8'h0B); send_run(8'hE0, 2); frame_close();
        chk(n_wr == 0, "R8 partial dropped", n_wr, 0);
        frame_open(); send_byte(8'h0B); send_run(8'h60, 4); frame_close();
        chk(n_wr == 1 && wd[0] == 32'h60616263, "R8 fresh word", wd[0], 32'h60616263);
    endtask

    // R11: profile and segment changes after the instruction are ignored
    task automatic t_sampled();
        clear_log();
        prof_sel = 2'd1;
        frame_open(); send_byte(8'h0B);
        prof_sel = 2'd3; set_seg(1, 0, 7);
        send_run(8'h70, 12); frame_close();
        chk(n_wr == 3, "R11 count", n_wr, 3);
        chk(wa[0] == 6 && wa[2] == 4, "R11 addresses", {wa[0], wa[2]}, {10'd6, 10'd4});
        set_seg(1, 4, 6);
    endtask

    initial begin
        set_seg(0, 3, 3);
        set_seg(1, 4, 6);
        set_seg(2, 8, 10);
        set_seg(3, 12, 9);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_msb_sweep();
        t_lsb_sweep();
        t_extra_bytes();
        t_reversed();
        t_bad_instr();
        t_partial();
        t_sampled();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule